// File: doc/BRIEF.md
# Dual-Identity Two-Wire Memory Slave

This block is a two-wire serial bus slave that answers to two device identities on one bus. The memory identity reaches an on-chip byte array. The master writes a 16-bit word address and then reads or writes bytes one after another. The register identity reaches a nine-entry clock and tamper register window. That window lives in a neighbouring block, which the slave drives through a plain address, write-data and write-strobe port. The neighbour returns read data on the same port without delay.

Both identities share one shift engine, one acknowledge path and one start/stop detector. Each identity has its own address pointer. A transfer to one identity never moves the other identity's pointer, so a current-address memory read can follow register traffic and resume where the memory left off. A power-fail input silences the slave completely. The bus pins are sampled with the system clock, and the open-drain data line is modelled as an active-high pull-down enable.

Top module: `dual_id_twowire_slave`

## Requirements
- R1: A write to identity MEM_ID (default 7'h50, direction bit 0 = write, 1 = read) takes two address bytes, high byte first, then data bytes that are stored at successive locations. Each byte is acknowledged by pulling the data line low in the ninth clock. A repeated start with the read direction returns those bytes in order.
- R2: Of the 16-bit memory address, only the low MEM_AW bits (default 11) select a location. Higher bits, including bit 15, are ignored.
- R3: The memory pointer advances by one after each byte written or read, and it wraps from the highest location (0x7FF by default) to location 0.
- R4: A write to identity REG_ID (default 7'h68) takes one address byte. Each data byte after it gives a one-clock pulse on reg_we, with reg_addr set to the register pointer and reg_wdata set to the byte.
- R5: The register pointer advances after each data byte, written or read, and wraps from 8 to 0. Read bytes are taken from reg_rdata.
- R6: A register address byte above 8 is not acknowledged, and it leaves the register pointer unchanged.
- R7: Each identity keeps its own pointer. A current-address memory read (read direction with no address phase) after register traffic returns the byte that follows the last memory byte accessed.
- R8: A slave address matching neither identity is not acknowledged, and the slave does not drive the data line for the rest of that transfer.
- R9: While pwr_fail is high the slave acknowledges nothing, stores no memory byte, raises no reg_we, and releases the data line within one clock.
- R10: After reset, after a stop, or after the master answers a read byte with a NACK, the slave releases the data line. It stays released until the next start. A stop in the middle of a write keeps the pointer already set.
- R11: The slave begins pulling the data line low only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_oe | output | 1 | High pulls the data line low |
| pwr_fail | input | 1 | High while supply is below the trip point; all traffic ignored |
| reg_addr | output | REG_AW | Register window index (pointer) |
| reg_wdata | output | 8 | Byte to write into the register window |
| reg_we | output | 1 | One-clock write strobe for the register window |
| reg_rdata | input | 8 | Register window contents at reg_addr |

## Verification
Memory traffic is tried with three address forms: a plain address, the same address with bit 15 set, and one with a bit just above the decoded range set. Matching read-back shows that the upper bits are really dropped. Bursts that cross the top location, and register bursts that cross index 8, separate a correct wrap from a pointer that runs past the end. Interleaved sequences carry the other cases: register traffic between two memory reads, an out-of-window register address, a foreign slave address, traffic under power fail, and a stop in the middle of a write. Each one shows whether one identity's pointer or storage was disturbed by traffic it should ignore.

// File: rtl/dual_id_twowire_slave.sv
module dual_id_twowire_slave #(
  parameter logic [6:0] MEM_ID = 7'h50,
  parameter logic [6:0] REG_ID = 7'h68,
  parameter int MEM_AW = 11,
  parameter int REG_N  = 9,
  parameter int REG_AW = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic              pwr_fail,
  output logic [REG_AW-1:0] reg_addr,
  output logic [7:0]        reg_wdata,
  output logic              reg_we,
  input  logic [7:0]        reg_rdata
);
  localparam int DEPTH = 1 << MEM_AW;
  localparam logic [7:0] REG_LAST_B = 8'(REG_N - 1);
  localparam logic [REG_AW-1:0] REG_LAST = REG_AW'(REG_N - 1);

  typedef enum logic [2:0] {S_IDLE, S_DEV, S_RX, S_ACKS, S_TX, S_ACKM} st_t;

  st_t st;
  logic [2:0] scl_q, sda_q, cnt;
  logic [7:0] sr, hi;
  logic [1:0] idx;
  logic drv, ackv, mack, sel_reg, to_tx;
  logic [MEM_AW-1:0] mptr;
  logic [REG_AW-1:0] rptr;
  logic [7:0] mem [DEPTH];

  wire scl_r = scl_q[1] & ~scl_q[2];
  wire scl_f = ~scl_q[1] & scl_q[2];
  wire scl_hi = scl_q[1] & scl_q[2];
  wire start = scl_hi & ~sda_q[1] & sda_q[2];
  wire stop  = scl_hi & sda_q[1] & ~sda_q[2];
  wire [7:0] byte_in = {sr[6:0], sda_q[1]};
  wire [15:0] full_addr = {hi, byte_in};
  wire [REG_AW-1:0] rnext = (rptr == REG_LAST) ? '0 : rptr + 1'b1;
  wire [7:0] tx_byte = sel_reg ? reg_rdata : mem[mptr];
  wire byte_done = (st == S_RX) && scl_r && (cnt == 3'd7) && !pwr_fail && !start && !stop;
  wire wr_mem = byte_done && !sel_reg && (idx == 2'd2);

  assign reg_we    = byte_done && sel_reg && (idx != 2'd0);
  assign reg_addr  = rptr;
  assign reg_wdata = byte_in;

  always_ff @(posedge clk) if (wr_mem) mem[mptr] <= byte_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= '1; sda_q <= '1;
    end else begin
      scl_q <= {scl_q[1:0], scl_i};
      sda_q <= {sda_q[1:0], sda_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; sr <= '0; hi <= '0; idx <= '0;
      drv <= 1'b0; ackv <= 1'b0; mack <= 1'b0; sel_reg <= 1'b0; to_tx <= 1'b0;
      mptr <= '0; rptr <= '0; sda_oe <= 1'b0;
    end else if (pwr_fail) begin
      st <= S_IDLE; sda_oe <= 1'b0;
    end else if (start) begin
      st <= S_DEV; cnt <= '0; sda_oe <= 1'b0;
    end else if (stop) begin
      st <= S_IDLE; sda_oe <= 1'b0;
    end else begin
      case (st)
        S_DEV, S_RX: if (scl_r) begin
          sr  <= byte_in;
          cnt <= cnt + 1'b1;
          if (cnt == 3'd7) begin
            st  <= S_ACKS;
            drv <= 1'b0;
            if (st == S_DEV) begin
              ackv    <= (byte_in[7:1] == MEM_ID) || (byte_in[7:1] == REG_ID);
              sel_reg <= (byte_in[7:1] == REG_ID);
              to_tx   <= byte_in[0];
              idx     <= '0;
            end else begin
              ackv  <= 1'b1;
              to_tx <= 1'b0;
              if (idx != 2'd2) idx <= idx + 1'b1;
              if (sel_reg) begin
                if (idx != 2'd0) rptr <= rnext;
                else if (byte_in <= REG_LAST_B) rptr <= byte_in[REG_AW-1:0];
                else ackv <= 1'b0;
              end else begin
                if (idx == 2'd0) hi <= byte_in;
                else if (idx == 2'd1) mptr <= full_addr[MEM_AW-1:0];
                else mptr <= mptr + 1'b1;
              end
            end
          end
        end
        S_ACKS: if (scl_f) begin
          if (!drv) begin
            drv <= 1'b1; sda_oe <= ackv;
          end else if (!ackv) begin
            sda_oe <= 1'b0; st <= S_IDLE;
          end else if (to_tx) begin
            sr <= tx_byte; sda_oe <= ~tx_byte[7]; st <= S_TX; cnt <= '0;
            if (sel_reg) rptr <= rnext; else mptr <= mptr + 1'b1;
          end else begin
            sda_oe <= 1'b0; st <= S_RX; cnt <= '0;
          end
        end
        S_TX: begin
          if (scl_r) begin
            cnt <= cnt + 1'b1;
            if (cnt == 3'd7) begin st <= S_ACKM; drv <= 1'b0; end
          end
          if (scl_f) begin sr <= {sr[6:0], 1'b0}; sda_oe <= ~sr[6]; end
        end
        S_ACKM: begin
          if (scl_r) mack <= ~sda_q[1];
          if (scl_f) begin
            if (!drv) begin
              drv <= 1'b1; sda_oe <= 1'b0;
            end else if (mack) begin
              sr <= tx_byte; sda_oe <= ~tx_byte[7]; st <= S_TX; cnt <= '0;
              if (sel_reg) rptr <= rnext; else mptr <= mptr + 1'b1;
            end else begin
              st <= S_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

module twowire_slave_chk #(
  parameter int REG_N  = 9,
  parameter int REG_AW = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scl_i,
  input logic              sda_oe,
  input logic              pwr_fail,
  input logic              reg_we,
  input logic [REG_AW-1:0] reg_addr
);
  localparam logic [REG_AW-1:0] LAST = REG_AW'(REG_N - 1);

  p_pwrfail_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_fail |=> !sda_oe);
  p_pwrfail_nowrite_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_fail |-> !reg_we);
  p_reg_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> (reg_addr <= LAST));
  p_we_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> !reg_we);
  p_drive_low_phase_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_i);
endmodule

bind dual_id_twowire_slave twowire_slave_chk #(.REG_N(REG_N), .REG_AW(REG_AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe),
  .pwr_fail(pwr_fail), .reg_we(reg_we), .reg_addr(reg_addr)
);

// File: tb/test_dual_id_twowire_slave.sv
module test_dual_id_twowire_slave;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 5;

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, m_sda = 1'b1, pwr_fail = 1'b0;
  logic sda_oe, reg_we;
  logic [3:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic [7:0] regs [9];
  logic [11:0] exp_q [$];
  int total = 0, bad = 0, hi_drive = 0;
  wire sda_line = m_sda & ~sda_oe;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign reg_rdata = (reg_addr < 4'd9) ? regs[reg_addr] : 8'h00;

  dual_id_twowire_slave i_dual_id_twowire_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe),
    .pwr_fail(pwr_fail), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_we(reg_we), .reg_rdata(reg_rdata));

  task automatic check(input string req, input logic [11:0] act, input logic [11:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Scoreboard monitor for register writes (R4, R5, R9)
  always @(negedge clk) begin
    logic prev_oe;
    if (reg_we) begin
      if (exp_q.size() == 0) check("R4/R9 unexpected reg write", {reg_addr, reg_wdata}, 12'hfff);
      else check("R4 reg write", {reg_addr, reg_wdata}, exp_q.pop_front());
      if (reg_addr < 4'd9) regs[reg_addr] <= reg_wdata;
    end
    if (sda_oe && !prev_oe && scl) hi_drive++;
    prev_oe = sda_oe;
  end

  task automatic wt; repeat (Q) @(negedge clk); endtask
  task automatic bstart; m_sda = 1; wt; scl = 1; wt; m_sda = 0; wt; scl = 0; wt; endtask
  task automatic rstart; m_sda = 1; wt; scl = 1; wt; m_sda = 0; wt; scl = 0; wt; endtask
  task automatic bstop; m_sda = 0; wt; scl = 1; wt; m_sda = 1; wt; endtask
  task automatic wbit(input logic b); m_sda = b; wt; scl = 1; wt; wt; scl = 0; wt; endtask
  task automatic rbit(output logic b); m_sda = 1; wt; scl = 1; wt; b = sda_line; wt; scl = 0; wt; endtask
  task automatic wbyte(input logic [7:0] d, output logic nack);
    for (int i = 7; i >= 0; i--) wbit(d[i]);
    rbit(nack);
  endtask
  task automatic rbyte(output logic [7:0] d, input logic more);
    for (int i = 7; i >= 0; i--) rbit(d[i]);
    wbit(!more);
  endtask

  logic n;
  logic [7:0] d;
  int nacks;

  task automatic wb(input logic [7:0] v); logic k; wbyte(v, k); if (k) nacks++; endtask
  task automatic mem_set(input logic [15:0] a); bstart; wb(8'hA0); wb(a[15:8]); wb(a[7:0]); endtask

  initial begin
    repeat (150000) @(negedge clk);
    check("R10 watchdog expired", 12'h1, 12'h0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 9; i++) regs[i] = 8'h30 + 8'(i);
    repeat (5) @(negedge clk);
    check("R10 reset releases line", {11'h0, sda_oe}, 12'h0);
    rst_n = 1;
    repeat (5) @(negedge clk);

    // R1: sequential write and read-back
    nacks = 0;
    mem_set(16'h0123); wb(8'h11); wb(8'h22); wb(8'h33); bstop;
    check("R1 write acks", 12'(nacks), 12'h0);
    mem_set(16'h0123); rstart; wb(8'hA1);
    rbyte(d, 1); check("R1 read byte0", {4'h0, d}, 12'h011);
    rbyte(d, 1); check("R1 read byte1", {4'h0, d}, 12'h022);
    rbyte(d, 0); check("R1 read byte2", {4'h0, d}, 12'h033);
    bstop;

    // R2: upper address bits ignored
    mem_set(16'h8040); wb(8'h5A); bstop;
    mem_set(16'h0040); rstart; wb(8'hA1); rbyte(d, 0); bstop;
    check("R2 bit15 ignored", {4'h0, d}, 12'h05A);
    mem_set(16'h0840); rstart; wb(8'hA1); rbyte(d, 0); bstop;
    check("R2 bit above range ignored", {4'h0, d}, 12'h05A);

    // R3: wrap at top of memory
    mem_set(16'h07FF); wb(8'hA1); wb(8'hA2); bstop;
    mem_set(16'h07FF); rstart; wb(8'hA1);
    rbyte(d, 1); check("R3 top byte", {4'h0, d}, 12'h0A1);
    rbyte(d, 0); check("R3 wrapped byte", {4'h0, d}, 12'h0A2);
    bstop;
    mem_set(16'h0000); rstart; wb(8'hA1); rbyte(d, 0); bstop;
    check("R3 location 0 holds wrapped write", {4'h0, d}, 12'h0A2);

    // R4: register writes
    nacks = 0;
    exp_q.push_back({4'd3, 8'h77}); exp_q.push_back({4'd4, 8'h78});
    bstart; wb(8'hD0); wb(8'h03); wb(8'h77); wb(8'h78); bstop;
    check("R4 acks", 12'(nacks), 12'h0);
    check("R4 all writes seen", 12'(exp_q.size()), 12'h0);

    // R5: register pointer wrap on write and read
    exp_q.push_back({4'd8, 8'h9A}); exp_q.push_back({4'd0, 8'h9B});
    bstart; wb(8'hD0); wb(8'h08); wb(8'h9A); wb(8'h9B); bstop;
    check("R5 wrap writes seen", 12'(exp_q.size()), 12'h0);
    bstart; wb(8'hD0); wb(8'h07); rstart; wb(8'hD1);
    rbyte(d, 1); check("R5 read idx7", {4'h0, d}, 12'h037);
    rbyte(d, 1); check("R5 read idx8", {4'h0, d}, 12'h09A);
    rbyte(d, 0); check("R5 read wrapped idx0", {4'h0, d}, 12'h09B);
    bstop;

    // R6: out-of-window register address
    bstart; wb(8'hD0); wbyte(8'h09, n); bstop;
    check("R6 address 9 not acked", {11'h0, n}, 12'h1);
    bstart; wb(8'hD1); rbyte(d, 0); bstop;
    check("R6 pointer unchanged", {4'h0, d}, 12'h031);

    // R7: independent pointers
    mem_set(16'h0123); rstart; wb(8'hA1); rbyte(d, 0); bstop;
    exp_q.push_back({4'd2, 8'h55});
    bstart; wb(8'hD0); wb(8'h02); wb(8'h55); bstop;
    bstart; wb(8'hA1); rbyte(d, 0); bstop;
    check("R7 memory resumes after register traffic", {4'h0, d}, 12'h022);

    // R8: foreign slave address
    bstart; wbyte(8'hD2, n);
    check("R8 foreign id not acked", {11'h0, n}, 12'h1);
    wbyte(8'h00, n);
    check("R8 no drive after mismatch", {11'h0, n}, 12'h1);
    bstop;

    // R9: power fail
    pwr_fail = 1;
    repeat (2) @(negedge clk);
    bstart; wbyte(8'hA0, n);
    check("R9 no ack under power fail", {11'h0, n}, 12'h1);
    wbyte(8'h01, n); wbyte(8'h23, n); wbyte(8'hEE, n); bstop;
    bstart; wbyte(8'hD0, n); wbyte(8'h05, n); wbyte(8'hFF, n); bstop;
    check("R9 no reg ack", {11'h0, n}, 12'h1);
    pwr_fail = 0;
    repeat (2) @(negedge clk);
    mem_set(16'h0123); rstart; wb(8'hA1); rbyte(d, 0); bstop;
    check("R9 memory untouched", {4'h0, d}, 12'h011);

    // R10: master NACK releases, stop keeps pointer
    bstart; wb(8'hA1); rbyte(d, 0);
    rbyte(d, 0);
    check("R10 released after master NACK", {4'h0, d}, 12'h0FF);
    bstop;
    mem_set(16'h0040); bstop;
    bstart; wb(8'hA1); rbyte(d, 0); bstop;
    check("R10 stop mid-write keeps pointer", {4'h0, d}, 12'h05A);

    // R11: drive only begins with SCL low
    check("R11 drive start while SCL high", 12'(hi_drive), 12'h0);
    check("R4 no stray writes", 12'(exp_q.size()), 12'h0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule